// File: doc/BRIEF.md
# Floating-Point Operand Pre-Check and NaN Selector

This purely combinational stage sits in front of a floating-point arithmetic unit. It inspects the operands of an add, subtract, multiply, divide, square root or fused multiply-add before any arithmetic starts. It handles flush-to-zero of denormal inputs, propagation of NaNs, detection of invalid operations and division by zero. When the outcome is already fixed by the operands, it raises an early-result-valid bit and supplies the final NaN result, so the arithmetic datapath result can be discarded.

The stage also drives the flushed operands, which the downstream datapath consumes. It raises three sticky-candidate flags: invalid, divide-by-zero and denormal-input. A format input selects half, single or double precision. Operands of narrower formats occupy the low bits of the 64-bit operand buses.

Top module: `fp_precheck`

## Requirements
- R1: `fmt` selects 0 = half (16 bits), 1 = single (32 bits) and 2 or 3 = double (64 bits). Operands sit right-aligned with IEEE field layout. Input bits above the format width are ignored and are driven as zero on every 64-bit output.
- R2: `op` encodes 0 = add a+b, 1 = subtract a-b, 2 = multiply a*b, 3 = divide a/b, 4 = square root of a, and 5 = fused a+b*c. Operands that the opcode does not use have no effect on any flag or early output.
- R3: With `ftz` set, every denormal operand is presented on its flushed output as a zero of its own sign. Otherwise the flushed output equals the input within the format width. All later checks see the flushed values.
- R4: `flag_den` is raised when `ftz` is set, the format is single or double, and a used operand is denormal. It is never raised for half precision, and it may accompany other flags.
- R5: Any used signaling NaN (exponent all ones, top fraction bit clear, fraction non-zero) raises `flag_inv` and gives an early result. That result is the first signaling NaN in the order a, b, c, made quiet by setting its top fraction bit while keeping its sign and remaining payload.
- R6: With `dnan` set, every early result is the default NaN. The default NaN is positive, with exponent all ones, top fraction bit one and all other fraction bits zero.
- R7: The following undefined operations raise `flag_inv` and give the default NaN as an early result, taking precedence over quiet-NaN operands:
  - infinities of opposite effective sign in add, subtract or the fused addend;
  - zero times infinity, including the fused product;
  - zero divided by zero;
  - infinity divided by infinity;
  - square root of a negative non-zero non-NaN value.
- R8: When only quiet NaNs are present, the early result is the first NaN operand in the order a, b, c, and no flag is raised.
- R9: Dividing a finite non-zero dividend by zero raises `flag_dz` without an early result.
- R10: With numeric operands and no undefined operation, `early_vld`, `early_res`, `flag_inv` and `flag_dz` stay zero, apart from the case in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fmt | input | 2 | Format select |
| op | input | 3 | Operation code |
| ftz | input | 1 | Flush denormal inputs to zero |
| dnan | input | 1 | Replace NaN results by the default NaN |
| a | input | 64 | Operand a (addend for fused op) |
| b | input | 64 | Operand b |
| c | input | 64 | Operand c (fused op only) |
| a_f | output | 64 | Flushed operand a |
| b_f | output | 64 | Flushed operand b |
| c_f | output | 64 | Flushed operand c |
| early_vld | output | 1 | Result settled without arithmetic |
| early_res | output | 64 | Early result value |
| flag_inv | output | 1 | Invalid operation |
| flag_dz | output | 1 | Division by zero |
| flag_den | output | 1 | Denormal input flushed |

## Verification
Every output is combinational, so each result is due in the same cycle its operands are applied. There is no register between input and output. The bench drives a new operand set on the falling clock edge and samples all outputs a quarter period later, well before the next rising edge. It sweeps every opcode, format and control setting against twelve signed special values per operand, comparing each output within that single cycle.

// File: rtl/fp_precheck.sv
module fp_precheck (
  input  logic [1:0]  fmt,
  input  logic [2:0]  op,
  input  logic        ftz,
  input  logic        dnan,
  input  logic [63:0] a,
  input  logic [63:0] b,
  input  logic [63:0] c,
  output logic [63:0] a_f,
  output logic [63:0] b_f,
  output logic [63:0] c_f,
  output logic        early_vld,
  output logic [63:0] early_res,
  output logic        flag_inv,
  output logic        flag_dz,
  output logic        flag_den
);
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_MUL = 3'd2,
                         OP_DIV = 3'd3, OP_SQRT = 3'd4, OP_FMA = 3'd5;

  logic [63:0] msk, top, sgn, dflt;
  logic [63:0] x   [3];
  logic [63:0] fl  [3];
  logic        s   [3];
  logic        e1  [3];
  logic        e0  [3];
  logic        fz  [3];
  logic        qb  [3];
  logic        den [3], zro [3], inf [3], nan [3], snan [3], fin [3], used [3];

  always_comb begin
    case (fmt)
      2'd0:    begin msk = 64'h0000_0000_0000_FFFF; top = 64'h0000_0000_0000_0200;
                     sgn = 64'h0000_0000_0000_8000; dflt = 64'h0000_0000_0000_7E00; end
      2'd1:    begin msk = 64'h0000_0000_FFFF_FFFF; top = 64'h0000_0000_0040_0000;
                     sgn = 64'h0000_0000_8000_0000; dflt = 64'h0000_0000_7FC0_0000; end
      default: begin msk = 64'hFFFF_FFFF_FFFF_FFFF; top = 64'h0008_0000_0000_0000;
                     sgn = 64'h8000_0000_0000_0000; dflt = 64'h7FF8_0000_0000_0000; end
    endcase
  end

  assign x[0] = a;
  assign x[1] = b;
  assign x[2] = c;
  assign used[0] = 1'b1;
  assign used[1] = (op != OP_SQRT);
  assign used[2] = (op == OP_FMA);

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      case (fmt)
        2'd0: begin
          s[i] = x[i][15]; e1[i] = &x[i][14:10]; e0[i] = ~|x[i][14:10];
          fz[i] = ~|x[i][9:0]; qb[i] = x[i][9];
        end
        2'd1: begin
          s[i] = x[i][31]; e1[i] = &x[i][30:23]; e0[i] = ~|x[i][30:23];
          fz[i] = ~|x[i][22:0]; qb[i] = x[i][22];
        end
        default: begin
          s[i] = x[i][63]; e1[i] = &x[i][62:52]; e0[i] = ~|x[i][62:52];
          fz[i] = ~|x[i][51:0]; qb[i] = x[i][51];
        end
      endcase
      den[i]  = e0[i] & ~fz[i];
      fl[i]   = (ftz & den[i]) ? (x[i] & sgn) : (x[i] & msk);
      zro[i]  = e0[i] & (fz[i] | ftz);
      inf[i]  = e1[i] & fz[i];
      nan[i]  = e1[i] & ~fz[i];
      snan[i] = nan[i] & ~qb[i];
      fin[i]  = ~e1[i] & ~zro[i];
    end
  end

  assign a_f = fl[0];
  assign b_f = fl[1];
  assign c_f = fl[2];

  logic any_snan, any_nan, undef, prod_undef, prod_inf;
  logic [63:0] snan_val, nan_val;

  always_comb begin
    any_snan = 1'b0;
    any_nan  = 1'b0;
    snan_val = '0;
    nan_val  = '0;
    for (int i = 2; i >= 0; i--) begin
      if (used[i] && snan[i]) begin any_snan = 1'b1; snan_val = fl[i] | top; end
      if (used[i] && nan[i])  begin any_nan  = 1'b1; nan_val  = fl[i];       end
    end
  end

  assign prod_undef = (zro[1] & inf[2]) | (inf[1] & zro[2]);
  assign prod_inf   = (inf[1] | inf[2]) & (inf[1] | fin[1]) & (inf[2] | fin[2]);

  always_comb begin
    case (op)
      OP_ADD:  undef = inf[0] & inf[1] & (s[0] ^ s[1]);
      OP_SUB:  undef = inf[0] & inf[1] & ~(s[0] ^ s[1]);
      OP_MUL:  undef = (zro[0] & inf[1]) | (inf[0] & zro[1]);
      OP_DIV:  undef = (zro[0] & zro[1]) | (inf[0] & inf[1]);
      OP_SQRT: undef = s[0] & ~zro[0] & ~nan[0];
      OP_FMA:  undef = prod_undef | (inf[0] & prod_inf & (s[0] ^ s[1] ^ s[2]));
      default: undef = 1'b0;
    endcase
  end

  always_comb begin
    early_vld = 1'b0;
    early_res = '0;
    flag_inv  = 1'b0;
    if (any_snan) begin
      early_vld = 1'b1;
      flag_inv  = 1'b1;
      early_res = dnan ? dflt : snan_val;
    end else if (undef) begin
      early_vld = 1'b1;
      flag_inv  = 1'b1;
      early_res = dflt;
    end else if (any_nan) begin
      early_vld = 1'b1;
      early_res = dnan ? dflt : nan_val;
    end
  end

  assign flag_dz  = (op == OP_DIV) & zro[1] & fin[0];
  assign flag_den = ftz & (fmt != 2'd0) &
                    ((used[0] & den[0]) | (used[1] & den[1]) | (used[2] & den[2]));
endmodule

module fp_precheck_chk (
  input logic [1:0]  fmt,
  input logic        ftz,
  input logic        dnan,
  input logic [63:0] a,
  input logic [63:0] a_f,
  input logic        early_vld,
  input logic [63:0] early_res,
  input logic        flag_inv,
  input logic        flag_dz,
  input logic        flag_den
);
  logic [63:0] m, d;
  logic        res_qnan;
  always_comb begin
    case (fmt)
      2'd0:    begin m = 64'hFFFF; d = 64'h7E00;
                     res_qnan = (&early_res[14:9]) && early_res[63:16] == '0; end
      2'd1:    begin m = 64'hFFFF_FFFF; d = 64'h7FC0_0000;
                     res_qnan = (&early_res[30:22]) && early_res[63:32] == '0; end
      default: begin m = '1; d = 64'h7FF8_0000_0000_0000;
                     res_qnan = &early_res[62:51]; end
    endcase
  end

  always_comb begin
    if (flag_den) p_den_fmt_r4: assert (ftz && fmt != 2'd0) else $error("den flag misuse");
    if (early_vld && dnan) p_default_nan_r6: assert (early_res == d) else $error("not default NaN");
    if (early_vld) p_early_qnan_r5: assert (res_qnan) else $error("early result not quiet NaN");
    if (flag_dz) p_dz_no_early_r9: assert (!early_vld && !flag_inv) else $error("dz with early");
    if (flag_inv) p_inv_early_r7: assert (early_vld) else $error("invalid without result");
    if (!ftz) p_pass_through_r3: assert (a_f == (a & m)) else $error("operand altered");
    if (!early_vld) p_idle_res_r10: assert (early_res == '0) else $error("stray early result");
  end
endmodule

bind fp_precheck fp_precheck_chk u_chk (
  .fmt(fmt), .ftz(ftz), .dnan(dnan), .a(a), .a_f(a_f),
  .early_vld(early_vld), .early_res(early_res),
  .flag_inv(flag_inv), .flag_dz(flag_dz), .flag_den(flag_den)
);

// File: tb/tb_fp_precheck.sv
module tb_fp_precheck;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]  fmt;
  logic [2:0]  op;
  logic        ftz, dnan;
  logic [63:0] a, b, c, a_f, b_f, c_f, early_res;
  logic        early_vld, flag_inv, flag_dz, flag_den;

  fp_precheck dut (.fmt(fmt), .op(op), .ftz(ftz), .dnan(dnan), .a(a), .b(b), .c(c),
                   .a_f(a_f), .b_f(b_f), .c_f(c_f), .early_vld(early_vld),
                   .early_res(early_res), .flag_inv(flag_inv), .flag_dz(flag_dz),
                   .flag_den(flag_den));

  localparam int K_ZERO = 0, K_DEN = 1, K_NORM = 2, K_INF = 3, K_QNAN = 4, K_SNAN = 5;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (fmt %0d op %0d ftz %0d dn %0d a %h b %h c %h)",
               tag, got, exp, fmt, op, ftz, dnan, a, b, c);
    end
  endtask

  function automatic int ew(input int f);
    return f == 0 ? 5 : (f == 1 ? 8 : 11);
  endfunction
  function automatic int fw(input int f);
    return f == 0 ? 10 : (f == 1 ? 23 : 52);
  endfunction

  function automatic logic [63:0] enc(input int f, input int k, input bit s);
    logic [63:0] e, fr, ones, topb;
    ones = (64'd1 << ew(f)) - 64'd1;
    topb = 64'd1 << (fw(f) - 1);
    case (k)
      K_ZERO: begin e = 0; fr = 0; end
      K_DEN:  begin e = 0; fr = 1; end
      K_NORM: begin e = (64'd1 << (ew(f) - 1)) - 64'd1; fr = 0; end
      K_INF:  begin e = ones; fr = 0; end
      K_QNAN: begin e = ones; fr = topb | 64'd1; end
      default: begin e = ones; fr = 64'd3; end
    endcase
    return (64'(s) << (ew(f) + fw(f))) | (e << fw(f)) | fr;
  endfunction

  task automatic run(input int f, input int o, input bit z, input bit dn, input bit junk,
                     input int va, input int vb, input int vc);
    int          kk[3];
    bit          ss[3];
    int          kf[3];
    logic [63:0] ev[3], fx[3];
    logic [63:0] jm, dflt, topb, xres;
    int          n, sn, qn;
    bit          undef, pu, pinf, xdz, xden, xinv, xvld;
    bit          ok[3];
    string       tag;
    int          vv[3];
    vv[0] = va; vv[1] = vb; vv[2] = vc;
    n = (o == 4) ? 1 : (o == 5 ? 3 : 2);
    jm = (f == 2) ? 64'd0 : ~((64'd1 << (1 + ew(f) + fw(f))) - 64'd1);
    jm = junk ? (jm & 64'hDEAD_BEEF_CAFE_F00D) : 64'd0;
    topb = 64'd1 << (fw(f) - 1);
    dflt = (((64'd1 << ew(f)) - 64'd1) << fw(f)) | topb;
    for (int i = 0; i < 3; i++) begin
      kk[i] = vv[i] / 2;
      ss[i] = vv[i][0];
      ev[i] = enc(f, kk[i], ss[i]);
      kf[i] = (kk[i] == K_DEN && z) ? K_ZERO : kk[i];
      fx[i] = (kk[i] == K_DEN && z) ? (64'(ss[i]) << (ew(f) + fw(f))) : ev[i];
      ok[i] = (kf[i] == K_DEN) || (kf[i] == K_NORM) || (kf[i] == K_INF);
    end
    sn = -1; qn = -1; xden = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (kf[i] == K_SNAN) sn = i;
      if (kf[i] == K_SNAN || kf[i] == K_QNAN) qn = i;
      if (kk[i] == K_DEN && z && f != 0) xden = 1;
    end
    pu = (kf[1] == K_ZERO && kf[2] == K_INF) || (kf[1] == K_INF && kf[2] == K_ZERO);
    pinf = (kf[1] == K_INF && ok[2]) || (kf[2] == K_INF && ok[1]);
    case (o)
      0: undef = kf[0] == K_INF && kf[1] == K_INF && ss[0] != ss[1];
      1: undef = kf[0] == K_INF && kf[1] == K_INF && ss[0] == ss[1];
      2: undef = (kf[0] == K_ZERO && kf[1] == K_INF) || (kf[0] == K_INF && kf[1] == K_ZERO);
      3: undef = (kf[0] == K_ZERO && kf[1] == K_ZERO) || (kf[0] == K_INF && kf[1] == K_INF);
      4: undef = ss[0] && (kf[0] == K_DEN || kf[0] == K_NORM || kf[0] == K_INF);
      default: undef = pu || (kf[0] == K_INF && pinf && (ss[0] ^ ss[1] ^ ss[2]));
    endcase
    xdz = (o == 3) && kf[1] == K_ZERO && (kf[0] == K_DEN || kf[0] == K_NORM);
    xinv = 0; xvld = 0; xres = 0; tag = "R10";
    if (sn >= 0) begin
      xinv = 1; xvld = 1; xres = dn ? dflt : (ev[sn] | topb); tag = "R5";
    end else if (undef) begin
      xinv = 1; xvld = 1; xres = dflt; tag = "R7";
    end else if (qn >= 0) begin
      xvld = 1; xres = dn ? dflt : ev[qn]; tag = "R8";
    end
    if (xvld && dn) tag = "R6";
    if (n < 3 && sn < 0 && qn < 0) tag = {tag, "/R2"};

    fmt = 2'(f); op = 3'(o); ftz = z; dnan = dn;
    a = ev[0] | jm; b = ev[1] | jm; c = ev[2] | jm;
    #5;
    chk(junk ? "R1 a_f" : "R3 a_f", a_f, fx[0]);
    chk(junk ? "R1 b_f" : "R3 b_f", b_f, fx[1]);
    chk(junk ? "R1 c_f" : "R3 c_f", c_f, fx[2]);
    chk("R4 flag_den", 64'(flag_den), 64'(xden));
    chk({tag, " early_vld"}, 64'(early_vld), 64'(xvld));
    chk({tag, " early_res"}, early_res, xres);
    chk({tag, " flag_inv"}, 64'(flag_inv), 64'(xinv));
    chk("R9 flag_dz", 64'(flag_dz), 64'(xdz));
  endtask

  initial begin
    fmt = 0; op = 0; ftz = 0; dnan = 0; a = 0; b = 0; c = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    chk("R10 reset early_vld", 64'(early_vld), 64'd0);
    chk("R10 reset flags", 64'({flag_inv, flag_dz, flag_den}), 64'd0);
    chk("R3 reset a_f", a_f, 64'd0);
    for (int f = 0; f < 3; f++)
      for (int o = 0; o < 6; o++)
        for (int z = 0; z < 2; z++)
          for (int dn = 0; dn < 2; dn++)
            for (int j = 0; j < 2; j++)
              for (int ia = 0; ia < 12; ia++)
                for (int ib = 0; ib < ((o == 4) ? 1 : 12); ib++)
                  for (int ic = 0; ic < ((o == 5) ? 12 : 1); ic++) begin
                    @(negedge clk);
                    run(f, o, z[0], dn[0], j[0], ia,
                        (o == 4) ? 11 : ib, (o == 5) ? ic : 11);
                  end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule